// File: doc/BRIEF.md
# Partitioning Register Access Trap Checker

This block sits beside the system-register access path of a processor core. For every access to one of the resource-partitioning control registers, it decides whether the access may proceed, must trap to level 2, must trap to level 3, or is undefined. The request carries:

- a register selector and the level issuing the access;
- platform bits: feature present, level 3 present, hypervisor enabled and level-2 host mode;
- the individual control bits that take part in the decision, taken from the level-3 control register, the level-2 control register, the hypervisor partitioning control register and the identification register.

The block registers the request, computes the decision and returns it one cycle later with a valid strobe. The core acts on the decision: it performs the access or raises the exception. The checks run in a fixed priority:

1. Undefined conditions.
2. The level-3 trap.
3. The level-2 trap that belongs to the selected register.
4. Otherwise, allow.

A small two-state machine (`ST_IDLE`, `ST_RESP`) tracks whether a response is being presented. These transitions are named:

- `IDLE_TO_RESP` on a request.
- `RESP_TO_RESP` on a back-to-back request.
- `RESP_TO_IDLE` when no request follows.

Requests may arrive on every cycle.

Top module: `part_trap_check`

## Requirements
- R1: A request sampled with `req_valid`=1 on a rising edge yields `resp_valid`=1 and its decision on `resp_code` right after the next edge. `resp_valid` is 0 after any edge where `req_valid` was 0. The decision codes are: 2'b00 allow, 2'b01 trap to level 2, 2'b10 trap to level 3, 2'b11 undefined.
- R2: With `feat_present`=0, every access decides 2'b11, whatever the selector, level and control bits.
- R3: An access issued from level 0 (`acc_level`=0) decides 2'b11.
- R4: The selector encodes the register: 0 identification, 1 level-0 register, 2 level-1 register, 3 level-1 alias, 4 level-2 class, 5 streaming-mode register. Codes 6 and 7 decide 2'b11. A level-2-class access from level 1 decides 2'b11.
- R5: For an access from level 1 or 2 that is not undefined, if `l3_present`=1 and `l3_trap_lower`=1 (level-3 register bit 62), the decision is 2'b10. This takes priority over every level-2 trap.
- R6: A level-1 identification access traps to level 2 (2'b01) when `hyp_enabled`=1, `id_has_hypctl`=1 and `hypctl_trap_id`=1 (hypervisor control bit 31). Failing that, it traps to level 2 when `hyp_enabled`=1, `id_has_tidr`=1 and `l2_trap_id`=1 (level-2 register bit 58).
- R7: A level-1 access to the level-0 register traps to level 2 when `hyp_enabled`=1 and `l2_trap_l0reg`=1 (bit 49). A level-1 access to the level-1 register traps to level 2 when `hyp_enabled`=1 and `l2_trap_l1reg`=1 (bit 48).
- R8: A level-1 access to the streaming-mode register traps to level 2 when `hyp_enabled`=1 and `l2_trap_smode`=1 (bit 50).
- R9: An alias access decides 2'b11 from level 1, and also from any level when `host_mode`=0. With `host_mode`=1 it follows the level-2 rule: only the level-3 trap applies.
- R10: Accesses from level 2 never receive 2'b01. Accesses from level 3 that are not undefined always decide 2'b00.
- R11: While `rst` is high, and after it, `resp_valid`=0 and `resp_code`=2'b00 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| reg_sel | input | 3 | Register selector |
| acc_level | input | 2 | Level issuing the access |
| feat_present | input | 1 | Partitioning feature implemented |
| l3_present | input | 1 | Level 3 implemented |
| hyp_enabled | input | 1 | Hypervisor level enabled for the current state |
| host_mode | input | 1 | Level 2 running in host mode |
| l3_trap_lower | input | 1 | Level-3 register bit 62, trap lower levels |
| l2_trap_id | input | 1 | Level-2 register bit 58, trap identification reads |
| l2_trap_smode | input | 1 | Level-2 register bit 50, trap streaming-mode register |
| l2_trap_l0reg | input | 1 | Level-2 register bit 49, trap level-0 register |
| l2_trap_l1reg | input | 1 | Level-2 register bit 48, trap level-1 register |
| hypctl_trap_id | input | 1 | Hypervisor control bit 31, trap identification reads |
| id_has_hypctl | input | 1 | Identification bit 17, hypervisor control implemented |
| id_has_tidr | input | 1 | Identification bit 58, trap-ID control implemented |
| resp_valid | output | 1 | Decision valid |
| resp_code | output | 2 | Decision code |

## Verification
Every decision is due exactly one rising edge after the edge that samples its request. No result is due for edges without a request.

The bench drives inputs on falling edges. It checks `resp_valid` and `resp_code` on the following falling edge, half a cycle after the edge that loads them. This holds for single and back-to-back requests alike, so every sampled request is paired with the expected decision of that same request. Idle cycles are checked for a low strobe and an unchanged code.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int SEL_W = 3;
    localparam int LVL_W = 2;
    localparam int DEC_W = 2;

    typedef enum logic [DEC_W-1:0] {
        DEC_ALLOW   = 2'b00,
        DEC_TRAP_L2 = 2'b01,
        DEC_TRAP_L3 = 2'b10,
        DEC_UNDEF   = 2'b11
    } ptc_dec_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_IDENT   = 3'd0,
        SEL_L0REG   = 3'd1,
        SEL_L1REG   = 3'd2,
        SEL_L1ALIAS = 3'd3,
        SEL_L2CLASS = 3'd4,
        SEL_SMODE   = 3'd5
    } ptc_sel_e;

    localparam logic [SEL_W-1:0] SEL_LAST = 3'd5;

    localparam logic [LVL_W-1:0] LVL_0 = 2'd0;
    localparam logic [LVL_W-1:0] LVL_1 = 2'd1;
    localparam logic [LVL_W-1:0] LVL_2 = 2'd2;
    localparam logic [LVL_W-1:0] LVL_3 = 2'd3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ptc_state_e;

endpackage

// File: rtl/ptc_avail.sv
// Undefined-access detection: feature absent, level 0, unknown selector,
// register not reachable from the issuing level, alias outside host mode.
module ptc_avail
    import ptc_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [LVL_W-1:0] lvl,
    input  logic             feat_present,
    input  logic             host_mode,
    output logic             undef
);
    always_comb begin
        undef = 1'b0;
        if (!feat_present) begin
            undef = 1'b1;
        end else if (lvl == LVL_0) begin
            undef = 1'b1;
        end else if (sel > SEL_LAST) begin
            undef = 1'b1;
        end else begin
            unique case (sel)
                SEL_L2CLASS: undef = (lvl == LVL_1);
                SEL_L1ALIAS: undef = (lvl == LVL_1) || !host_mode;
                default:     undef = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ptc_l2_rules.sv
// Level-2 trap source per selector, valid for level-1 accesses only.
module ptc_l2_rules
    import ptc_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             hyp_enabled,
    input  logic             l2_trap_id,
    input  logic             l2_trap_smode,
    input  logic             l2_trap_l0reg,
    input  logic             l2_trap_l1reg,
    input  logic             hypctl_trap_id,
    input  logic             id_has_hypctl,
    input  logic             id_has_tidr,
    output logic             l2_trap
);
    logic ident_by_hypctl;
    logic ident_by_l2;

    assign ident_by_hypctl = id_has_hypctl && hypctl_trap_id;
    assign ident_by_l2     = id_has_tidr && l2_trap_id;

    always_comb begin
        l2_trap = 1'b0;
        if (hyp_enabled) begin
            unique case (sel)
                SEL_IDENT:   l2_trap = ident_by_hypctl || ident_by_l2;
                SEL_L0REG:   l2_trap = l2_trap_l0reg;
                SEL_L1REG:   l2_trap = l2_trap_l1reg;
                SEL_SMODE:   l2_trap = l2_trap_smode;
                default:     l2_trap = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ptc_resp_fsm.sv
// Response sequencer: registers the decision and presents it for one cycle.
module ptc_resp_fsm
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [DEC_W-1:0] dec_in,
    output logic             resp_valid,
    output logic [DEC_W-1:0] resp_code
);
    ptc_state_e       state_q, state_d;
    logic [DEC_W-1:0] code_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;   // IDLE_TO_RESP
            ST_RESP: if (!req_valid) state_d = ST_IDLE;  // RESP_TO_IDLE, else RESP_TO_RESP
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= DEC_ALLOW;
        end else begin
            state_q <= state_d;
            if (req_valid) code_q <= dec_in;
        end
    end

    always_comb begin
        resp_valid = (state_q == ST_RESP);
        resp_code  = code_q;
    end
endmodule

// File: rtl/part_trap_check.sv
module part_trap_check
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [LVL_W-1:0] acc_level,
    input  logic             feat_present,
    input  logic             l3_present,
    input  logic             hyp_enabled,
    input  logic             host_mode,
    input  logic             l3_trap_lower,
    input  logic             l2_trap_id,
    input  logic             l2_trap_smode,
    input  logic             l2_trap_l0reg,
    input  logic             l2_trap_l1reg,
    input  logic             hypctl_trap_id,
    input  logic             id_has_hypctl,
    input  logic             id_has_tidr,
    output logic             resp_valid,
    output logic [DEC_W-1:0] resp_code
);
    logic             undef;
    logic             l2_trap;
    logic             l3_trap;
    logic [DEC_W-1:0] dec;

    ptc_avail avail_i (
        .sel          (reg_sel),
        .lvl          (acc_level),
        .feat_present (feat_present),
        .host_mode    (host_mode),
        .undef        (undef)
    );

    ptc_l2_rules l2_i (
        .sel            (reg_sel),
        .hyp_enabled    (hyp_enabled),
        .l2_trap_id     (l2_trap_id),
        .l2_trap_smode  (l2_trap_smode),
        .l2_trap_l0reg  (l2_trap_l0reg),
        .l2_trap_l1reg  (l2_trap_l1reg),
        .hypctl_trap_id (hypctl_trap_id),
        .id_has_hypctl  (id_has_hypctl),
        .id_has_tidr    (id_has_tidr),
        .l2_trap        (l2_trap)
    );

    // Level-3 trap reaches only the levels below it.
    assign l3_trap = l3_present && l3_trap_lower && (acc_level != LVL_3);

    always_comb begin
        if (undef)                               dec = DEC_UNDEF;
        else if (l3_trap)                        dec = DEC_TRAP_L3;
        else if (l2_trap && acc_level == LVL_1)  dec = DEC_TRAP_L2;
        else                                     dec = DEC_ALLOW;
    end

    ptc_resp_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .dec_in     (dec),
        .resp_valid (resp_valid),
        .resp_code  (resp_code)
    );
endmodule

// File: rtl/part_trap_check_chk.sv
module part_trap_check_chk
    import ptc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [SEL_W-1:0] reg_sel,
    input logic [LVL_W-1:0] acc_level,
    input logic             feat_present,
    input logic             l3_present,
    input logic             host_mode,
    input logic             l3_trap_lower,
    input logic             resp_valid,
    input logic [DEC_W-1:0] resp_code
);
    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);
    a_r1_code_held_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(resp_code));
    a_r2_absent_undef: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !feat_present) |=> (resp_code == 2'b11));
    a_r3_level0_undef: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_level == 2'd0) |=> (resp_code == 2'b11));
    a_r5_l3_wins: assert property (@(posedge clk) disable iff (rst)
        (req_valid && feat_present && acc_level == 2'd1 && reg_sel == 3'd0
         && l3_present && l3_trap_lower) |=> (resp_code == 2'b10));
    a_r9_alias_needs_host: assert property (@(posedge clk) disable iff (rst)
        (req_valid && reg_sel == 3'd3 && !host_mode) |=> (resp_code == 2'b11));
    a_r10_l2_never_traps_l2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_level == 2'd2) |=> (resp_code != 2'b01));
    a_r10_l3_level_allowed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && feat_present && acc_level == 2'd3 && reg_sel <= 3'd2)
        |=> (resp_code == 2'b00));
endmodule

bind part_trap_check part_trap_check_chk chk_i (.*);

// File: tb/part_trap_check_tb_top.sv
`timescale 1ns/1ps
module part_trap_check_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] reg_sel;
    logic [1:0] acc_level;
    logic       feat_present, l3_present, hyp_enabled, host_mode;
    logic       l3_trap_lower, l2_trap_id, l2_trap_smode, l2_trap_l0reg, l2_trap_l1reg;
    logic       hypctl_trap_id, id_has_hypctl, id_has_tidr;
    logic       resp_valid;
    logic [1:0] resp_code;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    part_trap_check dut_i (.*);

    // Reference decision from the requirements; tag names the deciding rule.
    function automatic logic [1:0] model(output string tag);
        if (!feat_present) begin tag = "R2"; return 2'b11; end
        if (acc_level == 2'd0) begin tag = "R3"; return 2'b11; end
        if (reg_sel > 3'd5) begin tag = "R4"; return 2'b11; end
        if (reg_sel == 3'd4 && acc_level == 2'd1) begin tag = "R4"; return 2'b11; end
        if (reg_sel == 3'd3 && (acc_level == 2'd1 || !host_mode)) begin
            tag = "R9"; return 2'b11;
        end
        if (acc_level == 2'd3) begin tag = "R10"; return 2'b00; end
        if (l3_present && l3_trap_lower) begin tag = "R5"; return 2'b10; end
        if (acc_level == 2'd2) begin tag = "R10"; return 2'b00; end
        case (reg_sel)
            3'd0: begin
                tag = "R6";
                if (hyp_enabled && id_has_hypctl && hypctl_trap_id) return 2'b01;
                if (hyp_enabled && id_has_tidr && l2_trap_id) return 2'b01;
                return 2'b00;
            end
            3'd1: begin tag = "R7"; return (hyp_enabled && l2_trap_l0reg) ? 2'b01 : 2'b00; end
            3'd2: begin tag = "R7"; return (hyp_enabled && l2_trap_l1reg) ? 2'b01 : 2'b00; end
            3'd5: begin tag = "R8"; return (hyp_enabled && l2_trap_smode) ? 2'b01 : 2'b00; end
            default: begin tag = "R10"; return 2'b00; end
        endcase
    endfunction

    task automatic check(input string tag, input logic v, input logic [1:0] c,
                         input logic ev, input logic [1:0] ec);
        checks++;
        if (v !== ev || c !== ec) begin
            failures++;
            $display("FAIL %s: valid=%0b code=%0b expected valid=%0b code=%0b",
                     tag, v, c, ev, ec);
        end
    endtask

    task automatic set_all(input logic [2:0] s, input logic [1:0] l, input logic [13:0] b);
        reg_sel = s; acc_level = l;
        {feat_present, l3_present, hyp_enabled, host_mode, l3_trap_lower,
         l2_trap_id, l2_trap_smode, l2_trap_l0reg, l2_trap_l1reg,
         hypctl_trap_id, id_has_hypctl, id_has_tidr} = b[11:0];
    endtask

    // Drive one request at a falling edge, check it at the next falling edge.
    task automatic directed(input logic [2:0] s, input logic [1:0] l, input logic [13:0] b);
        string tag;
        logic [1:0] exp;
        @(negedge clk);
        set_all(s, l, b);
        req_valid = 1'b1;
        exp = model(tag);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, resp_valid, resp_code, 1'b1, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: valid=%0b code=%0b expected completion", resp_valid, resp_code);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [1:0] exp_code;
        logic pend;
        logic [1:0] last_code;
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0;
        set_all(3'd0, 2'd1, 14'h0);
        repeat (3) @(negedge clk);
        check("R11", resp_valid, resp_code, 1'b0, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check("R11", resp_valid, resp_code, 1'b0, 2'b00);

        // bit order: feat,l3p,hyp,host,l3trap,l2id,l2sm,l2l0,l2l1,hypid,idhcr,idtidr
        directed(3'd0, 2'd1, 14'b00_0111_1111_1111);              // R2 absent
        directed(3'd2, 2'd0, 14'b00_1000_0000_0000);              // R3 level 0
        directed(3'd6, 2'd3, 14'b00_1000_0000_0000);              // R4 reserved
        directed(3'd4, 2'd1, 14'b00_1000_0000_0000);              // R4 level-2 class from 1
        directed(3'd0, 2'd1, 14'b00_1110_1000_0110);              // R5 over R6
        directed(3'd0, 2'd1, 14'b00_1010_0000_0110);              // R6 hypctl path
        directed(3'd0, 2'd1, 14'b00_1010_0000_0010);              // R6 hypctl missing -> allow
        directed(3'd0, 2'd1, 14'b00_1010_0100_0001);              // R6 tidr path
        directed(3'd1, 2'd1, 14'b00_1010_0001_0000);              // R7 level-0 reg
        directed(3'd1, 2'd1, 14'b00_1000_0001_0000);              // R7 hyp disabled
        directed(3'd2, 2'd1, 14'b00_1010_0000_1000);              // R7 level-1 reg
        directed(3'd5, 2'd1, 14'b00_1010_0010_0000);              // R8 streaming
        directed(3'd3, 2'd2, 14'b00_1010_0000_0000);              // R9 no host -> undef
        directed(3'd3, 2'd2, 14'b00_1011_0111_1111);              // R9 host, allow
        directed(3'd3, 2'd2, 14'b00_1111_1111_1111);              // R9 host, L3 trap
        directed(3'd2, 2'd2, 14'b00_1010_0111_1111);              // R10 level 2 no L2 trap
        directed(3'd5, 2'd3, 14'b00_1111_1111_1111);              // R10 level 3 allow

        // random phase, back-to-back requests allowed
        pend = 1'b0; last_code = resp_code; exp_code = 2'b00; tag = "R1";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (pend) begin
                check(tag, resp_valid, resp_code, 1'b1, exp_code);
                last_code = exp_code;
            end else begin
                check("R1", resp_valid, resp_code, 1'b0, last_code);
            end
            req_valid = ($urandom_range(0, 3) != 0);
            reg_sel   = 3'($urandom_range(0, 7));
            acc_level = 2'($urandom_range(0, 3));
            feat_present   = ($urandom_range(0, 9) != 0);
            l3_present     = 1'($urandom);
            hyp_enabled    = 1'($urandom);
            host_mode      = 1'($urandom);
            l3_trap_lower  = ($urandom_range(0, 3) == 0);
            l2_trap_id     = 1'($urandom);
            l2_trap_smode  = 1'($urandom);
            l2_trap_l0reg  = 1'($urandom);
            l2_trap_l1reg  = 1'($urandom);
            hypctl_trap_id = 1'($urandom);
            id_has_hypctl  = 1'($urandom);
            id_has_tidr    = 1'($urandom);
            pend = req_valid;
            if (pend) exp_code = model(tag);
        end
        @(negedge clk);
        if (pend) check(tag, resp_valid, resp_code, 1'b1, exp_code);
        req_valid = 1'b0;

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule